// File: doc/BRIEF.md
# Multidrop Address-Filtering Serial Receiver

This block receives asynchronous serial frames from a line that several nodes share. A frame carries a start bit, eight data bits sent least significant bit first, and then one of two endings. In nine-bit mode a ninth bit follows the data, and a stop bit follows that. In eight-bit mode only the stop bit follows the data. The bit clock comes from a fixed divider of the system clock. Each bit lasts sixteen sample ticks.

A filter can be switched on so that the host sees only traffic meant for its node. When the filter is on, a frame must have a ninth bit of 1 to be kept. In eight-bit mode the stop bit takes the place of the ninth bit. The frame's byte must also hit one of two addresses:

- The node's own address, compared only at the positions the mask selects.
- A broadcast address, formed from the address and the mask.

After the host has been addressed, it normally switches the filter off to take in the data frames that follow.

Top module: `mdrop_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `rx_byte` and all three flags read 0.
- R2: A sample tick occurs every `TICK_DIV` clocks, or every `TICK_DIV/2` clocks when `fast` is 1. Each bit lasts 16 ticks. The data bits arrive least significant bit first. Results update on the clock edge that ends the last bit of the frame.
- R3: Each bit is the majority of the line samples taken at ticks 7, 8 and 9. If the start bit votes high, it is a false start: the receiver returns to idle and changes no output.
- R4: In nine-bit mode (`mode9`=1) with `filt_en`=0, every completed frame loads `rx_byte` with the data and `rx_bit9` with the ninth bit, and sets `rx_done`. This holds whatever the value of the stop bit.
- R5: In eight-bit mode (`mode9`=0), the value of the stop bit is placed in `rx_bit9`.
- R6: With `filt_en`=1, a frame whose ninth bit is 0 leaves every output except `frame_err` unchanged.
- R7: With `filt_en`=1 and a ninth bit of 1, the frame is accepted if the byte equals `node_addr` at every position where `node_mask` is 1.
- R8: A frame with `filt_en`=1 and a ninth bit of 1 is also accepted if the byte has a 1 at every position where `node_addr | node_mask` is 1. A frame that hits neither address is dropped.
- R9: In eight-bit mode with `filt_en`=1, a frame is accepted only if its stop bit is 1 and its address matches.
- R10: Every completed frame sets `frame_err` to the inverse of its stop bit, whether or not the frame is accepted.
- R11: A frame that completes while `rx_done` is 1 is discarded, and `rx_byte` and `rx_bit9` keep their values.
- R12: Asserting `done_clr` while `rx_done` is 1 clears `rx_done` on the next edge. `rx_byte` and `rx_bit9` are held.
- R13: After the filter is switched off, data frames with a ninth bit of 0 are accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line; idles high |
| filt_en | input | 1 | Address filter enable |
| mode9 | input | 1 | 1: nine-bit frames; 0: eight-bit frames |
| fast | input | 1 | Doubles the bit rate |
| node_addr | input | 8 | Node address |
| node_mask | input | 8 | Address mask; a 0 bit is a don't-care position |
| done_clr | input | 1 | Clears the receive-done flag |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit) of the last accepted frame |
| rx_done | output | 1 | Receive-done flag |
| frame_err | output | 1 | Stop bit of the last completed frame was low |

## Verification
The bench uses the default `TICK_DIV` of 2. At this value a normal-rate bit lasts 32 clocks, and with `fast` set the tick runs on every clock, so both divider settings are exercised. A nine-bit frame lasts 352 clocks, which lets every filter case, the overrun case and the false start all run within a short test. The reference model predicts the exact edge on which each frame completes from the tick ratio.

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int TICK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       filt_en,
  input  logic       mode9,
  input  logic       fast,
  input  logic [7:0] node_addr,
  input  logic [7:0] node_mask,
  input  logic       done_clr,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       rx_done,
  output logic       frame_err
);
  localparam int PW = $clog2(TICK_DIV + 1);

  logic [1:0]    sy;
  logic          busy;
  logic [PW-1:0] pre;
  logic [3:0]    tcnt, bidx;
  logic [8:0]    sh;
  logic [2:0]    smp;

  wire           s     = sy[1];
  wire [PW-1:0]  lim   = fast ? PW'(TICK_DIV / 2) : PW'(TICK_DIV);
  wire           tick  = busy && (pre == lim - PW'(1));
  wire           vote  = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  wire [3:0]     last  = mode9 ? 4'd10 : 4'd9;
  wire           bend  = tick && (tcnt == 4'd15);
  wire           fin   = bend && (bidx == last);

  wire [7:0] byte_w  = mode9 ? sh[7:0] : sh[8:1];
  wire       ninth_w = mode9 ? sh[8] : vote;
  wire [7:0] bcast   = node_addr | node_mask;
  wire       hit     = (((byte_w ^ node_addr) & node_mask) == 8'h00) ||
                       ((byte_w & bcast) == bcast);
  wire       accept  = fin && !rx_done && (!filt_en || (ninth_w && hit));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pre  <= '0;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      smp  <= '0;
    end else if (!busy) begin
      if (!s) begin
        busy <= 1'b1;
        pre  <= '0;
        tcnt <= '0;
        bidx <= '0;
      end
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick) begin
        tcnt <= tcnt + 4'd1;
        if (tcnt >= 4'd7 && tcnt <= 4'd9) smp <= {s, smp[2:1]};
        if (bend) begin
          if ((bidx == 4'd0 && vote) || fin) busy <= 1'b0;
          else begin
            bidx <= bidx + 4'd1;
            if (bidx != 4'd0) sh <= {vote, sh[8:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte   <= '0;
      rx_bit9   <= 1'b0;
      rx_done   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (fin) frame_err <= !vote;
      if (accept) begin
        rx_byte <= byte_w;
        rx_bit9 <= ninth_w;
        rx_done <= 1'b1;
      end else if (done_clr) begin
        rx_done <= 1'b0;
      end
    end
  end

  // R11: held data survives while the flag stays up
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !done_clr |=> rx_done && $stable(rx_byte) && $stable(rx_bit9));

  // R12
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && done_clr |=> !rx_done && $stable(rx_byte));

  // R4: the flag rises only on a frame completion
  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(fin));

  // R6
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin && filt_en && !ninth_w && !rx_done |=> !rx_done);

  // R2: bit index never runs past the frame length
  p_bidx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bidx <= last);

  // R3: a false start ends reception without completing a frame
  p_false_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bend && bidx == 4'd0 && vote |=> !busy && $stable(rx_done));
endmodule

// File: tb/sim_mdrop_rx.sv
module sim_mdrop_rx;
  localparam int CLK_P = 10;
  localparam int TDIV  = 2;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic filt_en = 1'b0, mode9 = 1'b1, fast = 1'b0, done_clr = 1'b0;
  logic [7:0] node_addr = 8'h00, node_mask = 8'h00;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_done, frame_err;

  int cyc = 0, checks = 0, errors = 0, due = -1, clr_due = -1;
  string tag = "R1";
  logic [7:0] p_byte = 8'h00;
  logic p_b9 = 1'b0, p_stop = 1'b1;
  logic [7:0] e_byte = 8'h00;
  logic e_b9 = 1'b0, e_done = 1'b0, e_ferr = 1'b0;
  logic m_nin, m_hit;
  logic [7:0] m_bc;

  mdrop_rx #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .filt_en(filt_en), .mode9(mode9),
    .fast(fast), .node_addr(node_addr), .node_mask(node_mask),
    .done_clr(done_clr), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_done(rx_done), .frame_err(frame_err));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc == clr_due) e_done = 1'b0;
    if (cyc == due) begin
      m_nin = mode9 ? p_b9 : p_stop;
      m_bc  = node_addr | node_mask;
      m_hit = (((p_byte ^ node_addr) & node_mask) == 8'h00) || ((p_byte & m_bc) == m_bc);
      e_ferr = !p_stop;
      if (!e_done && (!filt_en || (m_nin && m_hit))) begin
        e_byte = p_byte;
        e_b9   = m_nin;
        e_done = 1'b1;
      end
    end
    chk("rx_byte", rx_byte, e_byte);
    chk("rx_bit9", rx_bit9, e_b9);
    chk("rx_done", rx_done, e_done);
    chk("frame_err", frame_err, e_ferr);
  end

  task automatic send(input logic [7:0] b, input logic b9, input logic stopv);
    int lim = fast ? TDIV / 2 : TDIV;
    int n = mode9 ? 11 : 10;
    logic [10:0] bits = mode9 ? {stopv, b9, b, 1'b0} : {1'b0, stopv, b, 1'b0};
    @(negedge clk);
    p_byte = b; p_b9 = b9; p_stop = stopv;
    due = cyc + 3 + 16 * lim * n;
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      repeat (16 * lim) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    clr_due = cyc + 1;
    @(negedge clk);
    done_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    tag = "R4";  send(8'hA5, 1'b0, 1'b1);
    tag = "R12"; clear_done();
    tag = "R2";  fast = 1'b1; send(8'h3C, 1'b1, 1'b1); fast = 1'b0;
    tag = "R12"; clear_done();
    tag = "R5";  mode9 = 1'b0; send(8'h81, 1'b0, 1'b1);
    tag = "R11"; send(8'h7E, 1'b0, 1'b1);
    tag = "R12"; clear_done();
    tag = "R10"; mode9 = 1'b1; send(8'h0F, 1'b1, 1'b0);
    clear_done();
    send(8'hF0, 1'b0, 1'b1);
    clear_done();

    node_addr = 8'h52; node_mask = 8'hF0; filt_en = 1'b1;
    tag = "R6";  send(8'h5E, 1'b0, 1'b1);
    tag = "R7";  send(8'h5E, 1'b1, 1'b1);
    clear_done();
    send(8'h62, 1'b1, 1'b1);
    tag = "R8";  send(8'hF7, 1'b1, 1'b1);
    clear_done();
    send(8'hE3, 1'b1, 1'b1);
    tag = "R13"; filt_en = 1'b0; clear_done();
    send(8'h11, 1'b0, 1'b1);
    clear_done();

    tag = "R9"; filt_en = 1'b1; mode9 = 1'b0;
    send(8'h53, 1'b0, 1'b1);
    clear_done();
    send(8'h53, 1'b0, 1'b0);
    send(8'h24, 1'b0, 1'b1);

    tag = "R3"; filt_en = 1'b0;
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * TDIV + 40) @(negedge clk);
    send(8'h99, 1'b0, 1'b1);

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog actual=running expected=finished", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule